// File: doc/BRIEF.md
# Parallel Minimum-Score Split Tracker

This block sits behind a bank of parallel attribute scoring units. In each cycle every unit presents one score for the same candidate split position. A pipelined comparator tree reduces those scores to the smallest one and the index of the attribute that produced it. That winner is then compared against a running best held across the whole stream. When a cycle's winner is strictly below the running best, the block records the new score together with the split position and the attribute index.

A run opens with a start strobe, which sets the running best to the largest representable score and discards any samples still in flight from the previous run. The caller then streams one sample per cycle with a valid flag and marks the final sample with a last flag. A short, fixed number of cycles after that final sample, the block pulses a result strobe. The recorded score, position, attribute and a found flag are then held steady until the next result.

Top module: `min_split_tracker`

## Requirements
- R1: After reset, `resultValid` and `bestFound` are 0 and `bestScore` is all ones.
- R2: The candidate for a cycle is the smallest of the NUM_UNITS scores, where unit i occupies bits `[i*SCORE_W +: SCORE_W]` of `scoreVec`.
- R3: When several units share the smallest score in a cycle, the candidate's attribute index is the lowest of those unit numbers.
- R4: A candidate replaces the running best only when it is strictly smaller. An equal score that arrives later leaves the earlier position and attribute in place.
- R5: On replacement, the split position presented with that sample and the winning attribute index are stored together with the score, and the published result carries all three.
- R6: Cycles with `scoreValid` low change nothing, whatever is on `scoreVec`, `splitPos` and `streamLast`; a last flag on an invalid cycle does not end the stream.
- R7: `runStart` sets the running best to all ones. If no sample in the run scores below all ones, the result reports `bestFound` = 0, score all ones, position 0 and attribute 0.
- R8: `resultValid` is a one-cycle pulse that appears LEVELS = ceil(log2(NUM_UNITS)) cycles after the clock edge that accepted a valid sample with `streamLast` high. The reported values include that sample and are held until the next pulse.
- R9: `runStart` discards samples from the previous run that are still inside the tree. A valid sample presented in the same cycle as `runStart` belongs to the new run.
- R10: Without a new `runStart`, a further stream continues from the running best left by the previous stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runStart | input | 1 | Clears the running best and flushes samples in flight |
| scoreValid | input | 1 | Marks the current cycle's scores as a real sample |
| streamLast | input | 1 | With scoreValid, marks the final sample of the stream |
| splitPos | input | POS_W | Split position shared by all scores of this cycle |
| scoreVec | input | NUM_UNITS*SCORE_W | One score per attribute unit, unit i at bits i*SCORE_W |
| resultValid | output | 1 | One-cycle pulse when a result is published |
| bestFound | output | 1 | At least one sample scored below all ones in the run |
| bestScore | output | SCORE_W | Smallest score seen in the run |
| bestPos | output | POS_W | Split position of the smallest score |
| bestAttr | output | IDX_W | Attribute index of the smallest score |

## Verification
The in-module properties assume that `rstN` is held low for at least one edge before streaming starts. They also assume that `scoreVec` and `splitPos` are stable across each sampling edge. They do not assume that invalid cycles carry sensible data, so the stimulus fills invalid cycles with small scores and raises a last flag on them, which a faulty design would be tempted to take. Scores are chosen so that ties occur both within one cycle and across cycles. The all-ones value is also used, so the strict-less rule and the clear value are exercised right at the top of the score range.

// File: rtl/split_pkg.sv
package split_pkg;

  // Strobes from the control path into the datapath, one per edge.
  typedef struct packed {
    logic clear;    // reset running best, takes priority
    logic update;   // tree output is a valid sample this edge
    logic publish;  // copy next running best into the result registers
  } trk_ctrl_t;

endpackage

// File: rtl/min_tree.sv
module min_tree #(
  parameter  int NUM_UNITS = 8,
  parameter  int SCORE_W   = 16,
  localparam int LEVELS    = $clog2(NUM_UNITS),
  localparam int IDX_W     = LEVELS
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_UNITS*SCORE_W-1:0]   scoreVec,
  output logic [SCORE_W-1:0]             minScore,
  output logic [IDX_W-1:0]               minIdx
);

  localparam int PADDED = 1 << LEVELS;
  localparam int INNER  = PADDED - 1;
  localparam int NODES  = 2 * PADDED - 1;

  // Heap layout: node n has children 2n+1 (lower indices) and 2n+2.
  // Leaves are combinational; every inner node is a register, so the
  // root appears LEVELS edges after the scores are sampled.
  logic [SCORE_W-1:0] nodeScore [NODES];
  logic [IDX_W-1:0]   nodeIdx   [NODES];

  for (genvar i = 0; i < PADDED; i++) begin : g_leaf
    if (i < NUM_UNITS) begin : g_real
      assign nodeScore[INNER+i] = scoreVec[i*SCORE_W +: SCORE_W];
    end else begin : g_pad
      assign nodeScore[INNER+i] = '1;
    end
    assign nodeIdx[INNER+i] = IDX_W'(i);
  end

  for (genvar n = 0; n < INNER; n++) begin : g_node
    localparam int LEFT  = 2 * n + 1;
    localparam int RIGHT = 2 * n + 2;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        nodeScore[n] <= '1;
        nodeIdx[n]   <= '0;
      end else if (nodeScore[RIGHT] < nodeScore[LEFT]) begin
        nodeScore[n] <= nodeScore[RIGHT];
        nodeIdx[n]   <= nodeIdx[RIGHT];
      end else begin
        nodeScore[n] <= nodeScore[LEFT];
        nodeIdx[n]   <= nodeIdx[LEFT];
      end
    end

    // R2: each stage never exceeds either of its inputs one edge earlier
    p_node_min_r2: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (nodeScore[n] <= $past(nodeScore[LEFT]) &&
                nodeScore[n] <= $past(nodeScore[RIGHT])));

    // R3: equal inputs keep the lower-index side
    p_tie_low_r3: assert property (@(posedge clk) disable iff (!rstN)
      (nodeScore[LEFT] == nodeScore[RIGHT]) |=> (nodeIdx[n] == $past(nodeIdx[LEFT])));
  end

  assign minScore = nodeScore[0];
  assign minIdx   = nodeIdx[0];

endmodule

// File: rtl/split_ctrl.sv
module split_ctrl
  import split_pkg::*;
#(
  parameter int LEVELS = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      runStart,
  input  logic      scoreValid,
  input  logic      streamLast,
  output trk_ctrl_t ctrl,
  output logic      resultValid
);

  // Valid and last flags travel alongside the tree, one bit per level.
  logic [LEVELS-1:0] validPipe;
  logic [LEVELS-1:0] lastPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validPipe <= '0;
      lastPipe  <= '0;
    end else begin
      validPipe[0] <= scoreValid;
      lastPipe[0]  <= scoreValid & streamLast;
      for (int i = 1; i < LEVELS; i++) begin
        validPipe[i] <= validPipe[i-1] & ~runStart;
        lastPipe[i]  <= lastPipe[i-1]  & ~runStart;
      end
    end
  end

  always_comb begin
    ctrl.clear   = runStart;
    ctrl.update  = validPipe[LEVELS-1] & ~runStart;
    ctrl.publish = lastPipe[LEVELS-1]  & ~runStart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= ctrl.publish;
  end

  // R9: a start strobe never produces a result on the following cycle
  p_no_publish_on_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    runStart |=> !resultValid);

  // R6: a publish only ever comes from a valid sample
  p_publish_needs_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.publish |-> ctrl.update);

endmodule

// File: rtl/split_datapath.sv
module split_datapath
  import split_pkg::*;
#(
  parameter  int NUM_UNITS = 8,
  parameter  int SCORE_W   = 16,
  parameter  int POS_W     = 12,
  localparam int LEVELS    = $clog2(NUM_UNITS),
  localparam int IDX_W     = LEVELS
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  trk_ctrl_t                    ctrl,
  input  logic                         resultValid,
  input  logic [POS_W-1:0]             splitPos,
  input  logic [NUM_UNITS*SCORE_W-1:0] scoreVec,
  output logic                         bestFound,
  output logic [SCORE_W-1:0]           bestScore,
  output logic [POS_W-1:0]             bestPos,
  output logic [IDX_W-1:0]             bestAttr
);

  logic [SCORE_W-1:0] treeScore;
  logic [IDX_W-1:0]   treeIdx;

  min_tree #(
    .NUM_UNITS(NUM_UNITS),
    .SCORE_W  (SCORE_W)
  ) u_tree (
    .clk     (clk),
    .rstN    (rstN),
    .scoreVec(scoreVec),
    .minScore(treeScore),
    .minIdx  (treeIdx)
  );

  // Position delay line matched to the tree latency.
  logic [POS_W-1:0] posPipe [LEVELS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LEVELS; i++) posPipe[i] <= '0;
    end else begin
      posPipe[0] <= splitPos;
      for (int i = 1; i < LEVELS; i++) posPipe[i] <= posPipe[i-1];
    end
  end

  // Running best over the stream.
  logic [SCORE_W-1:0] globMin;
  logic [POS_W-1:0]   globPos;
  logic [IDX_W-1:0]   globAttr;
  logic               globFound;

  logic               takeNew;
  logic [SCORE_W-1:0] nextMin;
  logic [POS_W-1:0]   nextPos;
  logic [IDX_W-1:0]   nextAttr;
  logic               nextFound;

  always_comb begin
    takeNew   = ctrl.update && (treeScore < globMin);
    nextMin   = takeNew ? treeScore         : globMin;
    nextPos   = takeNew ? posPipe[LEVELS-1] : globPos;
    nextAttr  = takeNew ? treeIdx           : globAttr;
    nextFound = takeNew | globFound;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clear) begin
      globMin   <= '1;
      globPos   <= '0;
      globAttr  <= '0;
      globFound <= 1'b0;
    end else begin
      globMin   <= nextMin;
      globPos   <= nextPos;
      globAttr  <= nextAttr;
      globFound <= nextFound;
    end
  end

  // Result registers, loaded only at the end of a stream.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bestScore <= '1;
      bestPos   <= '0;
      bestAttr  <= '0;
      bestFound <= 1'b0;
    end else if (ctrl.publish) begin
      bestScore <= nextMin;
      bestPos   <= nextPos;
      bestAttr  <= nextAttr;
      bestFound <= nextFound;
    end
  end

  // R4: the running best never rises without a clear
  p_monotonic_r4: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.clear |=> (globMin <= $past(globMin)));

  // R6: without a valid sample or a clear the running state is frozen
  p_hold_invalid_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.update && !ctrl.clear) |=>
      ($stable(globMin) && $stable(globPos) && $stable(globAttr) && $stable(globFound)));

  // R7: a clear restores the top score and drops the found flag
  p_clear_max_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clear |=> (globMin == {SCORE_W{1'b1}} && !globFound));

  // R7: found means something strictly below the top score was seen
  p_found_below_r7: assert property (@(posedge clk) disable iff (!rstN)
    globFound |-> (globMin != {SCORE_W{1'b1}}));

  // R5: a published result matches the running best of the same edge
  p_result_copy_r5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (bestScore == globMin && bestPos == globPos &&
                     bestAttr == globAttr && bestFound == globFound));

endmodule

// File: rtl/min_split_tracker.sv
module min_split_tracker
  import split_pkg::*;
#(
  parameter  int NUM_UNITS = 8,
  parameter  int SCORE_W   = 16,
  parameter  int POS_W     = 12,
  localparam int IDX_W     = $clog2(NUM_UNITS)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         runStart,
  input  logic                         scoreValid,
  input  logic                         streamLast,
  input  logic [POS_W-1:0]             splitPos,
  input  logic [NUM_UNITS*SCORE_W-1:0] scoreVec,
  output logic                         resultValid,
  output logic                         bestFound,
  output logic [SCORE_W-1:0]           bestScore,
  output logic [POS_W-1:0]             bestPos,
  output logic [IDX_W-1:0]             bestAttr
);

  localparam int LEVELS = $clog2(NUM_UNITS);

  trk_ctrl_t ctrl;

  split_ctrl #(
    .LEVELS(LEVELS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .runStart   (runStart),
    .scoreValid (scoreValid),
    .streamLast (streamLast),
    .ctrl       (ctrl),
    .resultValid(resultValid)
  );

  split_datapath #(
    .NUM_UNITS(NUM_UNITS),
    .SCORE_W  (SCORE_W),
    .POS_W    (POS_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .resultValid(resultValid),
    .splitPos   (splitPos),
    .scoreVec   (scoreVec),
    .bestFound  (bestFound),
    .bestScore  (bestScore),
    .bestPos    (bestPos),
    .bestAttr   (bestAttr)
  );

endmodule

// File: tb/sim_min_split_tracker.sv
`timescale 1ns/100ps
module sim_min_split_tracker;

  localparam int N      = 4;
  localparam int SW     = 16;
  localparam int PW     = 8;
  localparam int LEVELS = 2;

  typedef struct packed {
    logic [N*SW-1:0] a;
    logic [N*SW-1:0] b;
    logic [SW-1:0]   s;
    logic [PW-1:0]   p;
    logic [1:0]      at;
    logic            f;
  } vec_t;

  // Two-sample runs: sample a at position 10, sample b (last) at 11.
  // Unit 0 is the rightmost 16-bit field.
  localparam vec_t VECS [6] = '{
    '{64'h0028_001E_0014_0032, 64'h0005_003C_0046_0050, 16'h0005, 8'd11, 2'd3, 1'b1},
    '{64'h0009_0009_0064_0064, 64'h00C8_0009_00C8_00C8, 16'h0009, 8'd10, 2'd2, 1'b1},
    '{64'h0007_0007_0007_0007, 64'h0001_0002_0003_0004, 16'h0001, 8'd11, 2'd3, 1'b1},
    '{64'h012C_012C_012C_0002, 64'h0003_0003_0003_0003, 16'h0002, 8'd10, 2'd0, 1'b1},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 8'd0,  2'd0, 1'b0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFE_FFFF, 16'hFFFE, 8'd11, 2'd1, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          runStart = 1'b0;
  logic          scoreValid = 1'b0;
  logic          streamLast = 1'b0;
  logic [PW-1:0] splitPos = '0;
  logic [N*SW-1:0] scoreVec = '0;
  logic          resultValid;
  logic          bestFound;
  logic [SW-1:0] bestScore;
  logic [PW-1:0] bestPos;
  logic [1:0]    bestAttr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  min_split_tracker #(.NUM_UNITS(N), .SCORE_W(SW), .POS_W(PW)) u0 (
    .clk(clk), .rstN(rstN), .runStart(runStart), .scoreValid(scoreValid),
    .streamLast(streamLast), .splitPos(splitPos), .scoreVec(scoreVec),
    .resultValid(resultValid), .bestFound(bestFound), .bestScore(bestScore),
    .bestPos(bestPos), .bestAttr(bestAttr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic startRun();
    @(negedge clk);
    runStart = 1'b1; scoreValid = 1'b0; streamLast = 1'b0;
    @(posedge clk);
  endtask

  task automatic sendSample(input logic [N*SW-1:0] v, input logic [PW-1:0] p, input logic last);
    @(negedge clk);
    runStart = 1'b0; scoreValid = 1'b1; scoreVec = v; splitPos = p; streamLast = last;
    @(posedge clk);
  endtask

  task automatic sendInvalid(input logic [N*SW-1:0] v, input logic [PW-1:0] p);
    @(negedge clk);
    runStart = 1'b0; scoreValid = 1'b0; scoreVec = v; splitPos = p; streamLast = 1'b1;
    @(posedge clk);
  endtask

  // Called just after the edge that accepted the last sample.
  task automatic waitResult(input string req);
    int lat;
    lat = 0;
    @(negedge clk);
    runStart = 1'b0; scoreValid = 1'b0; streamLast = 1'b0;
    while (!resultValid && lat < 10) begin
      @(posedge clk); @(negedge clk);
      lat++;
    end
    chk(req, "latency", 32'(lat), 32'(LEVELS));
  endtask

  task automatic expectResult(input string req, input logic [SW-1:0] s, input logic [PW-1:0] p,
                              input logic [1:0] at, input logic f);
    chk(req, "score", 32'(bestScore), 32'(s));
    chk(req, "pos",   32'(bestPos),   32'(p));
    chk(req, "attr",  32'(bestAttr),  32'(at));
    chk(req, "found", 32'(bestFound), 32'(f));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "resultValid", 32'(resultValid), 32'd0);
    chk("R1", "found",       32'(bestFound),   32'd0);
    chk("R1", "score",       32'(bestScore),   32'hFFFF);
    rstN = 1'b1;

    // Table: R2 min over units, R3 ties, R4 strict-less, R5 pos/attr, R7 all-ones, R8 timing
    for (int k = 0; k < 6; k++) begin
      startRun();
      sendSample(VECS[k].a, 8'd10, 1'b0);
      chk("R8", "no early result", 32'(resultValid), 32'd0);
      sendSample(VECS[k].b, 8'd11, 1'b1);
      waitResult("R8");
      expectResult("R2 R3 R4 R5 R7", VECS[k].s, VECS[k].p, VECS[k].at, VECS[k].f);
      @(negedge clk);
      chk("R8", "single pulse", 32'(resultValid), 32'd0);
      chk("R8", "held score",   32'(bestScore),   32'(VECS[k].s));
    end

    // R6: invalid cycle with small scores and a last flag is ignored
    startRun();
    sendSample(64'h0064_0064_0032_0064, 8'd3, 1'b0);
    sendInvalid(64'h0000_0000_0000_0000, 8'd4);
    sendSample(64'h005A_005A_005A_005A, 8'd5, 1'b1);
    waitResult("R6");
    expectResult("R6", 16'h0032, 8'd3, 2'd1, 1'b1);

    // R10: no new start, larger scores keep the earlier best
    sendSample(64'h0070_0070_0070_0070, 8'd7, 1'b1);
    waitResult("R10");
    expectResult("R10", 16'h0032, 8'd3, 2'd1, 1'b1);
    // R10: no new start, smaller score replaces
    sendSample(64'h0070_0010_0070_0070, 8'd8, 1'b1);
    waitResult("R10");
    expectResult("R10", 16'h0010, 8'd8, 2'd2, 1'b1);

    // R9: in-flight sample of old run flushed, sample with start kept
    startRun();
    sendSample(64'h0001_0001_0001_0001, 8'd20, 1'b0);
    @(negedge clk);
    runStart = 1'b1; scoreValid = 1'b1; streamLast = 1'b1;
    scoreVec = 64'h01F0_01F4_01F4_01F4; splitPos = 8'd21;
    @(posedge clk);
    waitResult("R9");
    expectResult("R9", 16'h01F0, 8'd21, 2'd3, 1'b1);

    // R7: start alone clears; an all-ones stream reports not found
    startRun();
    sendSample(64'hFFFF_FFFF_FFFF_FFFF, 8'd30, 1'b1);
    waitResult("R7");
    expectResult("R7", 16'hFFFF, 8'd0, 2'd0, 1'b0);

    repeat (3) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule